// File: doc/BRIEF.md
# Coherence Invariant Monitor

This block is a synthesizable runtime checker for a directory-style coherence protocol that tracks one address. Each cycle it looks at the line state and line data of every caching node, the home's exclusive-grant flag and the home memory copy. It also sees each store request. From these it reports any breach of the control rules, which limit which combinations of line states may coexist, and of the data rules, which say that every valid copy, and memory while no exclusive grant is out, hold the latest written value.

The monitor keeps its own shadow register of the latest written value. While reset is held, the shadow loads the memory value, so the two start equal. After reset, a store changes the shadow only when it is accepted, that is, when the target node holds the line Exclusive. Errors are registered and sticky. A three-bit code tells control, cached-data and memory-data breaches apart, and a node index names the offender seen when the first error is latched.

Top module: `coh_mon`

## Requirements
- R1: Line states are 2-bit codes: 0 Invalid, 1 Shared, 2 Exclusive, 3 reserved. When a node is Exclusive and any other node is not Invalid, error code bit 0 (control) is set.
- R2: Any number of nodes may be Shared together without an error. A Shared node together with an Exclusive node at another index sets code bit 0.
- R3: A node showing the reserved state code 3 sets code bit 0, even if it is the only valid node.
- R4: A node that is not Invalid and whose data differs from the shadow value sets code bit 1. The data of an Invalid node is ignored.
- R5: With the exclusive flag clear, memory data that differs from the shadow value sets code bit 2. With the flag set, memory data is ignored.
- R6: A store whose target node is Exclusive in that cycle loads the store data into the shadow value at the clock edge. A store to a node that is not Exclusive leaves the shadow unchanged.
- R7: While rstN is low, the error outputs clear and the shadow value loads memData, so that memory and shadow start equal.
- R8: Error code bits are sticky until reset: once set they stay set, and new breaches only add bits. errAny is high exactly when some code bit is set.
- R9: errNode is written only when the first error is latched. It takes the lowest-indexed node with a control breach or, if there is none, the lowest-indexed node with a data breach, or 0 for a memory-only breach. It then holds until reset.
- R10: A breach present on the inputs during a cycle shows on the error outputs after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lineState | input | 2*NODES | Per-node line state, node i at bits [2i+1:2i] |
| lineData | input | NODES*DW | Per-node line data, node i at bits [i*DW +: DW] |
| exclFlag | input | 1 | Home exclusive-grant flag |
| memData | input | DW | Home memory copy |
| storeValid | input | 1 | Store request this cycle |
| storeNode | input | IW | Node issuing the store |
| storeData | input | DW | Value written by the store |
| errAny | output | 1 | Some error has been latched |
| errCode | output | 3 | Sticky breach bits: 0 control, 1 cached data, 2 memory data |
| errNode | output | IW | Offending node recorded for the first error |

## Verification
The control rules are tried with a legal group of sharers, two Exclusive holders, a sharer beside an Exclusive holder, and a lone reserved code. These separate a pairwise check that is too strict from one that is too loose. The data rules are tried with a stale valid copy, junk in an Invalid line, and stale memory with the exclusive flag set and then clear, which shows whether the validity and flag qualifiers are honoured. Accepted and ignored stores are each followed by data that agrees with exactly one candidate shadow value. Mixed simultaneous breaches and breaches after the first one show the priority and the holding of the offender index.

// File: rtl/coh_mon_pkg.sv
package coh_mon_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2,
    LINE_RSV = 2'd3
  } lineSt_e;

  // strobes from control to the datapath
  typedef struct packed {
    logic shadowInit;
    logic shadowLoad;
  } dpStrobe_t;

  localparam int CODE_W   = 3;
  localparam int CODE_CTL = 0;
  localparam int CODE_DAT = 1;
  localparam int CODE_MEM = 2;

endpackage

// File: rtl/coh_mon_dp.sv
module coh_mon_dp
  import coh_mon_pkg::*;
#(
  parameter int NODES = 4,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  dpStrobe_t             strobe,
  input  logic [2*NODES-1:0]    lineState,
  input  logic [NODES*DW-1:0]   lineData,
  input  logic                  exclFlag,
  input  logic [DW-1:0]         memData,
  input  logic [DW-1:0]         storeData,
  output logic [NODES-1:0]      dataBad,
  output logic                  memBad,
  output logic [DW-1:0]         shadowVal
);

  logic [DW-1:0] shadowQ;

  always_ff @(posedge clk) begin
    if (strobe.shadowInit)      shadowQ <= memData;
    else if (strobe.shadowLoad) shadowQ <= storeData;
  end

  for (genvar i = 0; i < NODES; i++) begin : g_cmp
    logic [1:0]    st;
    logic [DW-1:0] dat;
    assign st         = lineState[2*i +: 2];
    assign dat        = lineData[i*DW +: DW];
    assign dataBad[i] = (st != LINE_INV) && (dat != shadowQ);
  end

  assign memBad    = !exclFlag && (memData != shadowQ);
  assign shadowVal = shadowQ;

endmodule

// File: rtl/coh_mon_ctrl.sv
module coh_mon_ctrl
  import coh_mon_pkg::*;
#(
  parameter int NODES = 4,
  parameter int IW    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*NODES-1:0] lineState,
  input  logic               storeValid,
  input  logic [IW-1:0]      storeNode,
  input  logic [NODES-1:0]   dataBad,
  input  logic               memBad,
  output dpStrobe_t          strobe,
  output logic               errAny,
  output logic [CODE_W-1:0]  errCode,
  output logic [IW-1:0]      errNode
);

  logic [NODES-1:0]  ctrlBad;
  logic [NODES-1:0]  isExc;
  logic              storeHit;
  logic [CODE_W-1:0] newCode;
  logic [IW-1:0]     pickNode;
  logic [CODE_W-1:0] codeQ;
  logic [IW-1:0]     nodeQ;

  // pairwise control rule evaluation
  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      logic [1:0] si;
      logic       clash;
      si    = lineState[2*i +: 2];
      clash = 1'b0;
      for (int j = 0; j < NODES; j++) begin
        if (j != i) begin
          if ((si == LINE_EXC && lineState[2*j +: 2] != LINE_INV) ||
              (lineState[2*j +: 2] == LINE_EXC && si != LINE_INV))
            clash = 1'b1;
        end
      end
      ctrlBad[i] = (si == LINE_RSV) || clash;
      isExc[i]   = (si == LINE_EXC);
    end
  end

  always_comb begin
    storeHit = 1'b0;
    for (int i = 0; i < NODES; i++)
      if (storeNode == IW'(i) && isExc[i]) storeHit = 1'b1;
  end

  assign strobe.shadowInit = !rstN;
  assign strobe.shadowLoad = rstN && storeValid && storeHit;

  assign newCode[CODE_CTL] = |ctrlBad;
  assign newCode[CODE_DAT] = |dataBad;
  assign newCode[CODE_MEM] = memBad;

  // lowest control offender first, then lowest data offender
  always_comb begin
    pickNode = '0;
    if (|ctrlBad) begin
      for (int i = NODES - 1; i >= 0; i--)
        if (ctrlBad[i]) pickNode = IW'(i);
    end else begin
      for (int i = NODES - 1; i >= 0; i--)
        if (dataBad[i]) pickNode = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= '0;
      nodeQ <= '0;
    end else begin
      codeQ <= codeQ | newCode;
      if ((codeQ == '0) && (newCode != '0)) nodeQ <= pickNode;
    end
  end

  assign errCode = codeQ;
  assign errNode = nodeQ;
  assign errAny  = |codeQ;

endmodule

// File: rtl/coh_mon.sv
module coh_mon
  import coh_mon_pkg::*;
#(
  parameter int NODES = 4,
  parameter int DW    = 8,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*NODES-1:0] lineState,
  input  logic [NODES*DW-1:0] lineData,
  input  logic               exclFlag,
  input  logic [DW-1:0]      memData,
  input  logic               storeValid,
  input  logic [IW-1:0]      storeNode,
  input  logic [DW-1:0]      storeData,
  output logic               errAny,
  output logic [2:0]         errCode,
  output logic [IW-1:0]      errNode
);

  dpStrobe_t        strobe;
  logic [NODES-1:0] dataBad;
  logic             memBad;
  logic [DW-1:0]    shadowVal;

  coh_mon_ctrl #(.NODES(NODES), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineState(lineState),
    .storeValid(storeValid), .storeNode(storeNode),
    .dataBad(dataBad), .memBad(memBad), .strobe(strobe),
    .errAny(errAny), .errCode(errCode), .errNode(errNode)
  );

  coh_mon_dp #(.NODES(NODES), .DW(DW)) u_dp (
    .clk(clk), .strobe(strobe), .lineState(lineState),
    .lineData(lineData), .exclFlag(exclFlag), .memData(memData),
    .storeData(storeData), .dataBad(dataBad), .memBad(memBad),
    .shadowVal(shadowVal)
  );

endmodule

// File: rtl/coh_mon_chk.sv
module coh_mon_chk #(
  parameter int NODES = 4,
  parameter int DW    = 8,
  parameter int IW    = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [2*NODES-1:0] lineState,
  input logic               exclFlag,
  input logic [DW-1:0]      memData,
  input logic               storeValid,
  input logic [IW-1:0]      storeNode,
  input logic [DW-1:0]      storeData,
  input logic               errAny,
  input logic [2:0]         errCode,
  input logic [IW-1:0]      errNode,
  input logic [DW-1:0]      shadowVal
);

  int  excCnt;
  int  shrCnt;
  logic tgtExc;

  always_comb begin
    excCnt = 0;
    shrCnt = 0;
    tgtExc = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      if (lineState[2*i +: 2] == 2'd2) excCnt++;
      if (lineState[2*i +: 2] == 2'd1) shrCnt++;
      if (storeNode == IW'(i) && lineState[2*i +: 2] == 2'd2) tgtExc = 1'b1;
    end
  end

  p_two_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    (excCnt >= 2) |=> errCode[0]);

  p_shr_with_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    (excCnt >= 1 && shrCnt >= 1) |=> errCode[0]);

  p_stale_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!exclFlag && memData != shadowVal) |=> errCode[2]);

  p_shadow_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && tgtExc) |=> (shadowVal == $past(storeData)));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rstN |=> (errCode == 3'b000 && !errAny));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> errAny);

  p_node_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> $stable(errNode));

endmodule

bind coh_mon coh_mon_chk #(.NODES(NODES), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .lineState(lineState), .exclFlag(exclFlag),
  .memData(memData), .storeValid(storeValid), .storeNode(storeNode),
  .storeData(storeData), .errAny(errAny), .errCode(errCode),
  .errNode(errNode), .shadowVal(shadowVal)
);

// File: tb/coh_mon_test.sv
module coh_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int DW    = 8;
  localparam int IW    = 2;
  localparam logic [DW-1:0] INIT = 8'h3C;

  logic               clk = 1'b0;
  logic               rstN;
  logic [2*NODES-1:0] lineState;
  logic [NODES*DW-1:0] lineData;
  logic               exclFlag;
  logic [DW-1:0]      memData;
  logic               storeValid;
  logic [IW-1:0]      storeNode;
  logic [DW-1:0]      storeData;
  logic               errAny;
  logic [2:0]         errCode;
  logic [IW-1:0]      errNode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_mon #(.NODES(NODES), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .lineState(lineState), .lineData(lineData),
    .exclFlag(exclFlag), .memData(memData), .storeValid(storeValid),
    .storeNode(storeNode), .storeData(storeData), .errAny(errAny),
    .errCode(errCode), .errNode(errNode)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setNode(input int i, input logic [1:0] st, input logic [DW-1:0] d);
    lineState[2*i +: 2] = st;
    lineData[i*DW +: DW] = d;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineState = '0;
    for (int i = 0; i < NODES; i++) lineData[i*DW +: DW] = INIT;
    exclFlag = 1'b0;
    memData = INIT;
    storeValid = 1'b0;
    storeNode = '0;
    storeData = '0;
    step();
    step();
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    doReset();
    check("R7 code after reset", int'(errCode), 0);
    check("R7 errAny after reset", int'(errAny), 0);
    step();
    check("R7 memory equals shadow", int'(errCode), 0);
  endtask

  task automatic t_legalShared();
    doReset();
    setNode(0, 2'd1, INIT);
    setNode(2, 2'd1, INIT);
    setNode(3, 2'd1, INIT);
    step();
    check("R2 sharers legal", int'(errCode), 0);
  endtask

  task automatic t_twoExcl();
    doReset();
    setNode(1, 2'd2, INIT);
    setNode(2, 2'd2, INIT);
    #1;
    check("R10 not before edge", int'(errCode), 0);
    step();
    check("R1 two exclusive", int'(errCode), 1);
    check("R9 node two exclusive", int'(errNode), 1);
  endtask

  task automatic t_exclShared();
    doReset();
    setNode(0, 2'd1, INIT);
    setNode(3, 2'd2, INIT);
    step();
    check("R2 shared beside exclusive", int'(errCode), 1);
    check("R9 node shared beside exclusive", int'(errNode), 0);
  endtask

  task automatic t_rsvCode();
    doReset();
    setNode(2, 2'd3, INIT);
    step();
    check("R3 reserved code", int'(errCode), 1);
    check("R9 node reserved", int'(errNode), 2);
  endtask

  task automatic t_dataMis();
    doReset();
    setNode(1, 2'd0, 8'hEE);
    step();
    check("R4 invalid data ignored", int'(errCode), 0);
    setNode(2, 2'd1, INIT ^ 8'h01);
    step();
    check("R4 stale shared copy", int'(errCode), 2);
    check("R9 node stale copy", int'(errNode), 2);
  endtask

  task automatic t_mem();
    doReset();
    exclFlag = 1'b1;
    memData = 8'h99;
    step();
    check("R5 memory ignored with flag", int'(errCode), 0);
    exclFlag = 1'b0;
    step();
    check("R5 stale memory", int'(errCode), 4);
    check("R9 node memory only", int'(errNode), 0);
  endtask

  task automatic t_store();
    doReset();
    exclFlag = 1'b1;
    setNode(3, 2'd2, INIT);
    storeValid = 1'b1;
    storeNode = 2'd3;
    storeData = 8'h5A;
    step();
    storeValid = 1'b0;
    setNode(3, 2'd2, 8'h5A);
    step();
    check("R6 accepted store new data", int'(errCode), 0);
    setNode(3, 2'd0, 8'h00);
    exclFlag = 1'b0;
    memData = 8'h5A;
    step();
    check("R6 memory written back", int'(errCode), 0);
    memData = INIT;
    step();
    check("R6 old value now stale", int'(errCode), 4);
  endtask

  task automatic t_storeIgnored();
    doReset();
    setNode(1, 2'd1, INIT);
    storeValid = 1'b1;
    storeNode = 2'd1;
    storeData = 8'h77;
    step();
    storeValid = 1'b0;
    step();
    check("R6 ignored store keeps shadow", int'(errCode), 0);
    setNode(1, 2'd1, 8'h77);
    step();
    check("R6 ignored store value stale", int'(errCode), 2);
  endtask

  task automatic t_sticky();
    doReset();
    setNode(0, 2'd2, INIT);
    setNode(1, 2'd2, INIT);
    step();
    check("R1 two exclusive again", int'(errCode), 1);
    lineState = '0;
    step();
    step();
    check("R8 sticky after clear", int'(errCode), 1);
    check("R8 errAny held", int'(errAny), 1);
    setNode(3, 2'd1, 8'h00);
    step();
    check("R8 bits accumulate", int'(errCode), 3);
    check("R9 node held", int'(errNode), 0);
  endtask

  task automatic t_priority();
    doReset();
    setNode(0, 2'd1, 8'h11);
    setNode(3, 2'd3, INIT);
    step();
    check("R9 code mixed", int'(errCode), 3);
    check("R9 control before data", int'(errNode), 3);
  endtask

  initial begin
    rstN = 1'b0;
    lineState = '0;
    lineData = '0;
    exclFlag = 1'b0;
    memData = INIT;
    storeValid = 1'b0;
    storeNode = '0;
    storeData = '0;
    t_reset();
    t_legalShared();
    t_twoExcl();
    t_exclShared();
    t_rsvCode();
    t_dataMis();
    t_mem();
    t_store();
    t_storeIgnored();
    t_sticky();
    t_priority();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule